// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor that keeps procedure frames in registers. Architectural register numbers of 5 bits are translated to physical storage through a current window pointer. Each window sees four groups of eight registers. One group is the globals, shared by every window. The other three are its outgoing temporaries, its private locals and its incoming parameters. The outgoing group of one window is the same storage as the incoming group of the next window, so a caller hands arguments to a callee without any copy.

A call strobe moves the pointer one window forward and a return strobe moves it one window back, with wrap-around over a ring of windows. A saved-window pointer marks the oldest window still held in registers. When a call would run into that window, the block stops and raises an overflow trap naming the window to spill. When a return would land on a window that has already been spilled, the block raises an underflow trap naming the window to fill. A software handler moves the data and acknowledges the trap, and the held call or return then completes. A small controller with three states handles this. In RUN it accepts strobes. It moves RUN→SPILL_WAIT on an overflowing call, SPILL_WAIT→RUN on the spill acknowledge, RUN→FILL_WAIT on an underflowing return, and FILL_WAIT→RUN on the fill acknowledge.

Top module: `rwin_file`

## Requirements
- R1: After reset the current window is 0, the saved pointer is 0 with no windows spilled, every register reads 0, and ovf_trap, unf_trap and err are low.
- R2: Register numbers 0–7 address eight global registers that read the same in every window, and calls and returns do not change them.
- R3: In RUN a lone call moves the current window from w to (w+1) mod 8 at the next edge unless that value equals the saved pointer. A lone return moves it to (w−1) mod 8 unless w equals the saved pointer.
- R4: Numbers 8–15 are the outgoing group, 16–23 the locals and 24–31 the incoming group. Outgoing register 8+k of window w is the same storage as incoming register 24+k of window (w+1) mod 8. The locals of each window are private to it.
- R5: A write issued in the same cycle as a call is stored through the window that is current before the call.
- R6: A call with (w+1) mod 8 equal to the saved pointer enters SPILL_WAIT. There ovf_trap is high, spill_win equals the saved pointer and the window does not move. On spill_done the saved pointer and the current window both advance by one at the same edge, and the block returns to RUN.
- R7: A return while the current window equals the saved pointer, with at least one window spilled, enters FILL_WAIT. There unf_trap is high and fill_win equals (saved pointer − 1) mod 8. On fill_done the saved pointer and the current window both step back by one, and the block returns to RUN.
- R8: Call and return asserted together in RUN raise err in that cycle, and nothing changes.
- R9: A return while the current window equals the saved pointer, with no window spilled, raises err in that cycle and is ignored.
- R10: Call and return strobes arriving in SPILL_WAIT or FILL_WAIT are ignored.
- R11: Both read ports are combinational on the current window. A write lands at the clock edge, so a read of the same register in the write cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| rd_a_sel | input | 5 | Architectural register for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 5 | Architectural register for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Architectural register to write |
| wr_data | input | 32 | Write data |
| cwp | output | 3 | Current window pointer |
| ovf_trap | output | 1 | Overflow trap request (SPILL_WAIT) |
| spill_win | output | 3 | Window the handler must save |
| spill_done | input | 1 | Handler acknowledge of a spill |
| unf_trap | output | 1 | Underflow trap request (FILL_WAIT) |
| fill_win | output | 3 | Window the handler must restore |
| fill_done | input | 1 | Handler acknowledge of a fill |
| err | output | 1 | Rejected strobe combination |

## Verification
The hardest state to reach is an underflow. It exists only after the call depth has wrapped the ring at least once and forced spills, and after the returns have unwound back to the saved pointer. The bench builds a deep chain of calls that crosses the ring more than twice and acknowledges every overflow on the way. It then unwinds with more returns than calls. Each trap, fill window and final rejected return is predicted from a simple pointer-and-depth model kept in the bench. Data overlap between windows is swept over all eight offsets in seven consecutive windows.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    localparam int ARCH_AW = 5;
    localparam int GRP_W   = ARCH_AW - 2;
    localparam int GRP_SZ  = 1 << GRP_W;
    localparam int NGLOB   = GRP_SZ;

    typedef enum logic [1:0] {
        WS_RUN   = 2'd0,
        WS_SPILL = 2'd1,
        WS_FILL  = 2'd2
    } win_state_e;

    typedef enum logic [1:0] {
        RC_GLOBAL = 2'd0,
        RC_OUTS   = 2'd1,
        RC_LOCALS = 2'd2,
        RC_INS    = 2'd3
    } reg_class_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int PW   = $clog2(NGLOB + NWIN * 2 * GRP_SZ)
) (
    input  logic [CW-1:0]      cur_win,
    input  logic [ARCH_AW-1:0] arch_sel,
    output logic [PW-1:0]      phys_idx
);
    logic [CW-1:0]  nxt_win;
    logic [CW:0]    grp;
    reg_class_e     cls;

    assign nxt_win = (cur_win == CW'(NWIN - 1)) ? '0 : cur_win + 1'b1;
    assign cls     = reg_class_e'(arch_sel[ARCH_AW-1:GRP_W]);

    always_comb begin
        grp      = '0;
        phys_idx = PW'(arch_sel[GRP_W-1:0]);
        unique case (cls)
            RC_GLOBAL: phys_idx = PW'(arch_sel[GRP_W-1:0]);
            RC_OUTS: begin
                grp      = {nxt_win, 1'b0};
                phys_idx = PW'(NGLOB) + PW'({grp, arch_sel[GRP_W-1:0]});
            end
            RC_LOCALS: begin
                grp      = {cur_win, 1'b1};
                phys_idx = PW'(NGLOB) + PW'({grp, arch_sel[GRP_W-1:0]});
            end
            RC_INS: begin
                grp      = {cur_win, 1'b0};
                phys_idx = PW'(NGLOB) + PW'({grp, arch_sel[GRP_W-1:0]});
            end
            default: phys_idx = PW'(arch_sel[GRP_W-1:0]);
        endcase
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int DEPTH = 136,
    parameter int W     = 32,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [PW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [PW-1:0] w_idx,
    input  logic [W-1:0]  w_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];

    // R11: a write is present in storage after its edge
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int SW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_done,
    input  logic          fill_done,
    output logic [CW-1:0] cwp,
    output logic          ovf_trap,
    output logic [CW-1:0] spill_win,
    output logic          unf_trap,
    output logic [CW-1:0] fill_win,
    output logic          err
);
    win_state_e    st, st_n;
    logic [CW-1:0] swp, cwp_n, swp_n;
    logic [SW-1:0] saved, saved_n;
    logic          err_c;

    function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] v);
        return (v == CW'(NWIN - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [CW-1:0] wrap_dec(input logic [CW-1:0] v);
        return (v == '0) ? CW'(NWIN - 1) : v - 1'b1;
    endfunction

    // state and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= WS_RUN;
            cwp   <= '0;
            swp   <= '0;
            saved <= '0;
        end else begin
            st    <= st_n;
            cwp   <= cwp_n;
            swp   <= swp_n;
            saved <= saved_n;
        end
    end

    // transitions
    always_comb begin
        st_n    = st;
        cwp_n   = cwp;
        swp_n   = swp;
        saved_n = saved;
        err_c   = 1'b0;
        unique case (st)
            WS_RUN: begin
                if (call_i && ret_i) begin
                    err_c = 1'b1;
                end else if (call_i) begin
                    if (wrap_inc(cwp) == swp) st_n = WS_SPILL;
                    else                      cwp_n = wrap_inc(cwp);
                end else if (ret_i) begin
                    if (cwp == swp) begin
                        if (saved != '0) st_n  = WS_FILL;
                        else             err_c = 1'b1;
                    end else begin
                        cwp_n = wrap_dec(cwp);
                    end
                end
            end
            WS_SPILL: begin
                if (spill_done) begin
                    swp_n   = wrap_inc(swp);
                    saved_n = saved + 1'b1;
                    cwp_n   = wrap_inc(cwp);
                    st_n    = WS_RUN;
                end
            end
            WS_FILL: begin
                if (fill_done) begin
                    swp_n   = wrap_dec(swp);
                    saved_n = saved - 1'b1;
                    cwp_n   = wrap_dec(cwp);
                    st_n    = WS_RUN;
                end
            end
            default: st_n = WS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        ovf_trap  = (st == WS_SPILL);
        unf_trap  = (st == WS_FILL);
        spill_win = swp;
        fill_win  = wrap_dec(swp);
        err       = err_c;
    end

    assert_call_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_RUN && call_i && !ret_i && wrap_inc(cwp) != swp)
        |=> (cwp == wrap_inc($past(cwp))));

    assert_spill_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap && !spill_done) |=> ($stable(cwp) && $stable(swp) && ovf_trap));

    assert_fill_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_trap && fill_done)
        |=> (swp == wrap_dec($past(swp)) && cwp == wrap_dec($past(cwp)) && !unf_trap));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> ($stable(cwp) && $stable(swp) && !ovf_trap && !unf_trap));
endmodule

// File: rtl/rwin_file.sv
module rwin_file
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int W    = 32,
    parameter int SW   = 16,
    localparam int CW    = $clog2(NWIN),
    localparam int DEPTH = NGLOB + NWIN * 2 * GRP_SZ,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic [ARCH_AW-1:0] rd_a_sel,
    output logic [W-1:0]       rd_a_data,
    input  logic [ARCH_AW-1:0] rd_b_sel,
    output logic [W-1:0]       rd_b_data,
    input  logic               wr_en,
    input  logic [ARCH_AW-1:0] wr_sel,
    input  logic [W-1:0]       wr_data,
    output logic [CW-1:0]      cwp,
    output logic               ovf_trap,
    output logic [CW-1:0]      spill_win,
    input  logic               spill_done,
    output logic               unf_trap,
    output logic [CW-1:0]      fill_win,
    input  logic               fill_done,
    output logic               err
);
    localparam int NPORT = 3;

    logic [ARCH_AW-1:0] sel  [NPORT];
    logic [PW-1:0]      pidx [NPORT];

    assign sel[0] = rd_a_sel;
    assign sel[1] = rd_b_sel;
    assign sel[2] = wr_sel;

    rwin_ctrl #(.NWIN(NWIN), .CW(CW), .SW(SW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_i     (call_i),
        .ret_i      (ret_i),
        .spill_done (spill_done),
        .fill_done  (fill_done),
        .cwp        (cwp),
        .ovf_trap   (ovf_trap),
        .spill_win  (spill_win),
        .unf_trap   (unf_trap),
        .fill_win   (fill_win),
        .err        (err)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cur_win  (cwp),
            .arch_sel (sel[g]),
            .phys_idx (pidx[g])
        );
    end

    rwin_store #(.DEPTH(DEPTH), .W(W), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (pidx[0]),
        .ra_data (rd_a_data),
        .rb_idx  (pidx[1]),
        .rb_data (rd_b_data),
        .we      (wr_en),
        .w_idx   (pidx[2]),
        .w_data  (wr_data)
    );

    // R6/R7: the two trap requests never coexist
    assert_one_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));
endmodule

// File: tb/rwin_file_test.sv
`timescale 1ns/1ps
module rwin_file_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0;
    logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  cwp, spill_win, fill_win;
    logic        ovf_trap, unf_trap, err;
    logic        spill_done = 1'b0, fill_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cwp_m, swp_m, saved_m;

    always #10 clk = ~clk;

    rwin_file uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cwp(cwp), .ovf_trap(ovf_trap), .spill_win(spill_win), .spill_done(spill_done),
        .unf_trap(unf_trap), .fill_win(fill_win), .fill_done(fill_done), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = 5'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_a_sel = 5'(a);
        #1;
        d = rd_a_data;
    endtask

    task automatic do_call();
        call_i = 1'b1;
        tick();
        call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1;
        tick();
        ret_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 cwp", 32'(cwp), 0);
        chk("R1 ovf", 32'(ovf_trap), 0);
        chk("R1 unf", 32'(unf_trap), 0);
        chk("R1 err", 32'(err), 0);
        for (int a = 0; a < 32; a++) begin
            rd_b_sel = 5'(31 - a);
            rd(a, v);
            chk("R1 portA zero", v, 0);
            chk("R1 portB zero", rd_b_data, 0);
        end

        // R2: globals
        for (int i = 0; i < 8; i++) wr(i, 32'hA000 + 32'(i));

        // R3/R4/R2: climb through windows 0..7
        for (int w = 0; w < 7; w++) begin
            for (int k = 0; k < 8; k++) begin
                wr(16 + k, 32'h1000 * 32'(w + 1) + 32'(k));
                wr(8 + k, 32'h2000_0000 + 32'h100 * 32'(w) + 32'(k));
            end
            do_call();
            chk("R3 call advance", 32'(cwp), 32'(w + 1));
            for (int k = 0; k < 8; k++) begin
                rd(24 + k, v);
                chk("R4 outs become ins", v, 32'h2000_0000 + 32'h100 * 32'(w) + 32'(k));
                rd(k, v);
                chk("R2 global visible", v, 32'hA000 + 32'(k));
            end
        end

        // R3/R4: descend back to window 0
        for (int w = 6; w >= 0; w--) begin
            do_ret();
            chk("R3 return retreat", 32'(cwp), 32'(w));
            for (int k = 0; k < 8; k++) begin
                rd(16 + k, v);
                chk("R4 private locals", v, 32'h1000 * 32'(w + 1) + 32'(k));
                rd(8 + k, v);
                chk("R4 outs kept", v, 32'h2000_0000 + 32'h100 * 32'(w) + 32'(k));
            end
        end

        // R9: return at the bottom with nothing spilled
        ret_i = 1'b1;
        #1;
        chk("R9 err on empty return", 32'(err), 1);
        tick();
        ret_i = 1'b0;
        chk("R9 cwp kept", 32'(cwp), 0);
        chk("R9 no underflow", 32'(unf_trap), 0);

        // R8: call and return together
        call_i = 1'b1; ret_i = 1'b1;
        #1;
        chk("R8 err", 32'(err), 1);
        tick();
        call_i = 1'b0; ret_i = 1'b0;
        chk("R8 cwp kept", 32'(cwp), 0);
        chk("R8 no trap", 32'(ovf_trap), 0);

        // R11: write not visible until the edge
        wr_en = 1'b1; wr_sel = 5'd16; wr_data = 32'h5555;
        rd(16, v);
        chk("R11 old value before edge", v, 32'h1001 - 32'h1);
        tick();
        wr_en = 1'b0;
        rd(16, v);
        chk("R11 new value after edge", v, 32'h5555);

        // R5: write with call uses pre-call window
        wr_en = 1'b1; wr_sel = 5'd11; wr_data = 32'hBEEF;
        call_i = 1'b1;
        tick();
        wr_en = 1'b0; call_i = 1'b0;
        chk("R5 cwp", 32'(cwp), 1);
        rd(27, v);
        chk("R5 write through old window", v, 32'hBEEF);

        // R6/R10: deep call chain wrapping the ring
        cwp_m = 1; swp_m = 0; saved_m = 0;
        for (int n = 0; n < 20; n++) begin
            bit expect_ovf;
            expect_ovf = (((cwp_m + 1) % 8) == swp_m);
            do_call();
            if (expect_ovf) begin
                chk("R6 ovf_trap", 32'(ovf_trap), 1);
                chk("R6 spill_win", 32'(spill_win), 32'(swp_m));
                chk("R6 cwp held", 32'(cwp), 32'(cwp_m));
                ret_i = 1'b1;
                tick();
                ret_i = 1'b0;
                chk("R10 ret ignored in wait", 32'(cwp), 32'(cwp_m));
                chk("R10 still waiting", 32'(ovf_trap), 1);
                spill_done = 1'b1;
                tick();
                spill_done = 1'b0;
                swp_m = (swp_m + 1) % 8;
                saved_m++;
                chk("R6 trap cleared", 32'(ovf_trap), 0);
            end
            cwp_m = (cwp_m + 1) % 8;
            chk("R3 call chain cwp", 32'(cwp), 32'(cwp_m));
        end

        // R7/R9/R10: unwind past the bottom
        for (int n = 0; n < 24; n++) begin
            if (cwp_m == swp_m && saved_m == 0) begin
                ret_i = 1'b1;
                #1;
                chk("R9 err at bottom", 32'(err), 1);
                tick();
                ret_i = 1'b0;
                chk("R9 cwp held", 32'(cwp), 32'(cwp_m));
            end else if (cwp_m == swp_m) begin
                do_ret();
                chk("R7 unf_trap", 32'(unf_trap), 1);
                chk("R7 fill_win", 32'(fill_win), 32'((swp_m + 7) % 8));
                chk("R7 cwp held", 32'(cwp), 32'(cwp_m));
                call_i = 1'b1;
                tick();
                call_i = 1'b0;
                chk("R10 call ignored in wait", 32'(cwp), 32'(cwp_m));
                fill_done = 1'b1;
                tick();
                fill_done = 1'b0;
                swp_m = (swp_m + 7) % 8;
                saved_m--;
                cwp_m = (cwp_m + 7) % 8;
                chk("R7 cwp after fill", 32'(cwp), 32'(cwp_m));
                chk("R7 trap cleared", 32'(unf_trap), 0);
            end else begin
                do_ret();
                cwp_m = (cwp_m + 7) % 8;
                chk("R3 unwind cwp", 32'(cwp), 32'(cwp_m));
            end
        end

        // R2: globals survive everything
        for (int k = 0; k < 8; k++) begin
            rd(k, v);
            chk("R2 globals after traps", v, 32'hA000 + 32'(k));
        end

        finish_run();
    end
endmodule